// File: doc/BRIEF.md
# Shared Thread FIFO Cell

This block is one word-queue cell that several hardware threads use to pass data to each other. Every request names a thread index, a direction and an access view. A store pushes a word at the tail and a load pops the oldest word. The cell keeps an Empty tag, a Full tag and a fill count. All of them change by themselves as words come and go.

There are two views onto the same queue. The waiting view refuses any load from an empty cell and any store to a full cell. It answers "blocked" in the same cycle and records the thread in a parked-thread mask. The next access that gets past the blocking check sends one wake pulse to every parked thread and clears the mask. A woken thread must issue its access again. The non-waiting view never refuses a request. It drops a store to a full cell, and a load from an empty cell returns zero.

A configuration input switches queue mode on. While it is off, every load returns zero and every store has no effect.

Top module: `itc_fifo_cell`

## Requirements
- R1: After reset the fill count is 0, Empty is 1, Full is 0, the parked mask is 0 and the wake vector is 0.
- R2: A store that proceeds enqueues its data. A load that proceeds returns the oldest stored word on `rsp_rdata` in the same cycle and removes it.
- R3: Empty goes to 1 when a load leaves the count at zero, and any store in queue mode clears it. Full goes to 1 when a store brings the count to DEPTH, and any load in queue mode clears it.
- R4: A waiting-view load (`req_view`=0) while Empty is 1 gives `rsp_blocked`=1 and `rsp_rdata`=0. It leaves the queue unchanged and sets bit `req_tid` of the parked mask.
- R5: A waiting-view store while Full is 1 gives `rsp_blocked`=1 and leaves the queue contents and count unchanged. It sets bit `req_tid` of the parked mask.
- R6: A non-waiting-view store (`req_view`=1) to a full cell is dropped. The count stays at DEPTH and the stored words are unchanged.
- R7: A non-waiting-view load from an empty cell returns 0 and never raises `rsp_blocked`.
- R8: While `cfg_fifo_en` is 0, loads return 0, stores have no effect, nothing blocks, and the tags, mask and wake vector are unchanged.
- R9: When an access proceeds past the blocking check with a nonzero parked mask, `wake_pulse` equals that mask for exactly the next cycle and the mask becomes 0. Otherwise `wake_pulse` is 0.
- R10: Storage is circular. The tail slot is the read pointer plus the count, modulo DEPTH, and the read pointer wraps modulo DEPTH, so order is kept across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_en | input | 1 | Queue mode enable |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Cell accepts a request (every cycle) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_view | input | 1 | 0 = waiting view, 1 = non-waiting view |
| req_tid | input | 3 | Requesting thread index |
| req_wdata | input | 64 | Store data |
| rsp_blocked | output | 1 | Access refused; thread is parked |
| rsp_rdata | output | 64 | Load data (0 if nothing popped) |
| empty_flag | output | 1 | Empty tag |
| full_flag | output | 1 | Full tag |
| fill_count | output | 3 | Words held |
| parked_mask | output | 8 | Parked-thread mask |
| wake_pulse | output | 8 | One-cycle wake vector |

## Verification
The bench builds the cell with its defaults: DEPTH=4, 64-bit words and 8 threads. With a depth of four, random traffic reaches both Full and Empty often and wraps the read pointer many times. Eight thread indices let several distinct threads park together, so the wake vector is checked with more than one bit set. Runs with queue mode off mixed in show that those requests have no effect.

// File: rtl/itc_cell_pkg.sv
package itc_cell_pkg;
  typedef enum logic {VIEW_WAIT = 1'b0, VIEW_TRY = 1'b1} view_e;

  // circular slot index: (base + off) mod depth
  function automatic int slot_wrap(input int base, input int off, input int depth);
    return (base + off) % depth;
  endfunction

  // one-hot bit for a thread index
  function automatic logic [63:0] tid_bit(input int tid);
    return 64'd1 << tid;
  endfunction
endpackage

// File: rtl/itc_cell_queue.sv
module itc_cell_queue #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count
);
  import itc_cell_pkg::*;

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  tail_ptr;

  assign tail_ptr  = PTR_W'(slot_wrap(int'(rd_ptr), int'(count), DEPTH));
  assign head_data = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) slots[tail_ptr] <= wdata;
      if (pop)  rd_ptr <= PTR_W'(slot_wrap(int'(rd_ptr), 1, DEPTH));
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(count) < DEPTH)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0)); // R7
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R2
endmodule

// File: rtl/itc_cell_waitmask.sv
module itc_cell_waitmask #(
  parameter int THREADS = 8,
  localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               park,
  input  logic [TID_W-1:0]   park_tid,
  input  logic               release_all,
  output logic [THREADS-1:0] mask,
  output logic [THREADS-1:0] wake
);
  import itc_cell_pkg::*;

  logic [THREADS-1:0] park_bit;
  assign park_bit = THREADS'(tid_bit(int'(park_tid)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      wake <= '0;
    end else begin
      wake <= release_all ? mask : '0;
      if (release_all)   mask <= '0;
      else if (park)     mask <= mask | park_bit;
    end
  end

  AST_WAKE_IS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    release_all |=> (wake == $past(mask)) && (mask == '0)); // R9
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake != '0) |=> (wake == '0) || $past(release_all)); // R9
  AST_PARK_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> mask[$past(park_tid)]); // R4
endmodule

// File: rtl/itc_fifo_cell.sv
module itc_fifo_cell #(
  parameter int DEPTH   = 4,
  parameter int DATA_W  = 64,
  parameter int THREADS = 8,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_fifo_en,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_view,
  input  logic [TID_W-1:0]   req_tid,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_blocked,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               empty_flag,
  output logic               full_flag,
  output logic [CNT_W-1:0]   fill_count,
  output logic [THREADS-1:0] parked_mask,
  output logic [THREADS-1:0] wake_pulse
);
  import itc_cell_pkg::*;

  // named internal events
  logic             ld_req, st_req, is_wait;
  logic             proceed, do_push, do_pop, release_all;
  logic [DATA_W-1:0] head_data;
  logic [CNT_W-1:0]  cnt_next;
  logic             empty_q, full_q;

  assign req_ready = 1'b1;
  assign ld_req  = req_valid && cfg_fifo_en && !req_write;
  assign st_req  = req_valid && cfg_fifo_en &&  req_write;
  assign is_wait = (view_e'(req_view) == VIEW_WAIT);

  assign rsp_blocked = is_wait && ((ld_req && empty_q) || (st_req && full_q));
  assign proceed     = (ld_req || st_req) && !rsp_blocked;
  assign do_pop      = ld_req && proceed && (fill_count != '0);
  assign do_push     = st_req && proceed && (int'(fill_count) < DEPTH);
  assign release_all = proceed && (parked_mask != '0);
  assign cnt_next    = fill_count + CNT_W'(do_push) - CNT_W'(do_pop);
  assign rsp_rdata   = do_pop ? head_data : '0;

  itc_cell_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
    .wdata(req_wdata), .head_data(head_data), .count(fill_count));

  itc_cell_waitmask #(.THREADS(THREADS)) u_wait (
    .clk(clk), .rst_n(rst_n), .park(rsp_blocked), .park_tid(req_tid),
    .release_all(release_all), .mask(parked_mask), .wake(wake_pulse));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      if (st_req)
        empty_q <= 1'b0;
      else if (do_pop && cnt_next == '0)
        empty_q <= 1'b1;
      if (ld_req)
        full_q <= 1'b0;
      else if (do_push && int'(cnt_next) == DEPTH)
        full_q <= 1'b1;
    end
  end

  assign empty_flag = empty_q;
  assign full_flag  = full_q;

  AST_EMPTY_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    empty_flag == (fill_count == '0)); // R3
  AST_FULL_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    full_flag == (int'(fill_count) == DEPTH)); // R3
  AST_BLOCK_FREEZES_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_blocked |=> $stable(fill_count)); // R5
  AST_TRY_NEVER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_view) |-> !rsp_blocked); // R7
  AST_DISABLED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cfg_fifo_en) |=> $stable(fill_count) && $stable(parked_mask)
      && (wake_pulse == '0)); // R8
endmodule

// File: tb/tb_itc_fifo_cell.sv
module tb_itc_fifo_cell;
  localparam int DEPTH = 4, DW = 64, NT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_fifo_en = 1'b1, req_valid = 1'b0, req_write = 1'b0, req_view = 1'b0;
  logic [2:0] req_tid = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_blocked, empty_flag, full_flag;
  logic [DW-1:0] rsp_rdata;
  logic [2:0] fill_count;
  logic [NT-1:0] parked_mask, wake_pulse;

  always #2 clk = ~clk; // 250 MHz

  itc_fifo_cell dut (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] mq [DEPTH];
  int mrp = 0, mcnt = 0;
  bit mE = 1, mF = 0;
  logic [NT-1:0] mmask = '0;

  function automatic int wrap_add(int a, int b);
    int s = a + b;
    while (s >= DEPTH) s -= DEPTH;
    return s;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic op(bit wr, bit trymode, int tid, logic [DW-1:0] d, bit en, string tag);
    bit eblk = 0;
    logic [DW-1:0] erd = '0;
    logic [NT-1:0] ewake = '0;
    if (en) begin
      if (!wr) mF = 0; else mE = 0;
      if (!trymode && ((!wr && mE) || (wr && mF))) begin
        eblk = 1;
        mmask |= NT'(1) << tid;
      end else begin
        ewake = mmask;
        mmask = '0;
        if (!wr) begin
          if (mcnt > 0) begin erd = mq[mrp]; mrp = wrap_add(mrp, 1); mcnt--; end
          if (mcnt == 0) mE = 1;
        end else begin
          if (mcnt < DEPTH) begin mq[wrap_add(mrp, mcnt)] = d; mcnt++; end
          if (mcnt == DEPTH) mF = 1;
        end
      end
    end
    @(negedge clk);
    req_valid = 1; req_write = wr; req_view = trymode; req_tid = 3'(tid);
    req_wdata = d; cfg_fifo_en = en;
    #1;
    chk({tag, " blocked"}, DW'(rsp_blocked), DW'(eblk));
    chk({tag, " rdata"}, rsp_rdata, erd);
    @(posedge clk); #1;
    req_valid = 0;
    chk({tag, " count"}, DW'(fill_count), DW'(mcnt));
    chk({tag, " empty/full"}, DW'({empty_flag, full_flag}), DW'({mE, mF}));
    chk({tag, " mask"}, DW'(parked_mask), DW'(mmask));
    chk({tag, " wake"}, DW'(wake_pulse), DW'(ewake));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 count", DW'(fill_count), 0);
    chk("R1 tags", DW'({empty_flag, full_flag}), DW'(2'b10));
    chk("R1 mask/wake", DW'({parked_mask, wake_pulse}), 0);
    chk("R1 ready", DW'(req_ready), 1);
    // R7 try load on empty; R4 waiting load parks threads 2 and 5
    op(0, 1, 0, 0, 1, "R7 try-read-empty");
    op(0, 0, 2, 0, 1, "R4 wait-read-empty");
    op(0, 0, 5, 0, 1, "R4 wait-read-empty t5");
    // R9 store releases both; R2 order; R3 full after DEPTH pushes
    for (int i = 0; i < DEPTH; i++) op(1, i[0], 1, 64'hA000 + i, 1, "R9 R2 R3 fill");
    op(1, 0, 7, 64'hBAD, 1, "R5 wait-write-full");
    op(1, 1, 3, 64'hDEAD, 1, "R6 try-write-full");
    // R8 disabled: nothing changes
    op(0, 0, 4, 0, 0, "R8 disabled read");
    op(1, 1, 4, 64'h55, 0, "R8 disabled write");
    for (int i = 0; i < DEPTH; i++) op(0, 0, 6, 0, 1, "R9 R2 R3 drain");
    // R10 wrap: many pushes/pops around the ring
    for (int i = 0; i < 3 * DEPTH; i++) begin
      op(1, 1, 0, 64'hC00 + i, 1, "R10 wrap push");
      op(0, 1, 0, 0, 1, "R10 wrap pop");
    end
    // random traffic
    for (int i = 0; i < 1500; i++) begin
      op(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), $urandom_range(0, NT - 1),
         {$urandom, $urandom}, ($urandom_range(0, 15) != 0), "R2 R3 R4 R5 R9 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule